// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit core and a word-organised data memory. For each memory request it decodes the load or store opcode into an access size and an extension rule. It forms the byte address by adding the sign-extended 16-bit displacement to the base operand. It then registers a memory command that carries the address, the read or write strobe, the lane enables and the write data with the low byte or halfword copied into every lane. A misaligned halfword or word request is flagged, and it reaches memory with no lanes enabled.

On the return side, the block takes the read word together with the opcode and the low address bits of that load. It picks out the addressed byte or halfword and widens it to 32 bits, with sign or zero fill chosen by the opcode. Both paths are single-cycle registered pipelines with a synchronous active-high reset.

Top module: `ldst_lane_align`

## Requirements
- R1: Of the opcode values 0x20, 0x21, 0x23, 0x24, 0x25 (loads) and 0x28, 0x29, 0x2b (stores), any one presented with `req_valid` high gives `acc_valid` high on the next clock edge. Any other opcode, or `req_valid` low, gives `acc_valid` low and `acc_rd`, `acc_wr`, `acc_be` and `acc_misalign` all zero.
- R2: `acc_addr` equals `req_base` plus the 16-bit `req_disp` sign-extended to 32 bits, modulo 2^32. A zero base therefore gives the displacement alone as the address, and a zero displacement gives the base alone.
- R3: Lanes are little-endian, and lane k covers data bits [8k+7:8k]. A byte access enables only lane `addr[1:0]`. A halfword access enables 4'b0011 when `addr[1]`=0 and 4'b1100 when `addr[1]`=1. A word access enables 4'b1111. Loads and stores use the same enables.
- R4: For a store, `acc_wdata` is `{4{src[7:0]}}` for a byte (0x28), `{2{src[15:0]}}` for a halfword (0x29) and `src` for a word (0x2b). For a load it is zero.
- R5: `acc_misalign` is 1 for a halfword access (0x21, 0x25, 0x29) with `addr[0]`=1 and for a word access (0x23, 0x2b) with `addr[1:0]`≠0. In that case `acc_be`, `acc_rd` and `acc_wr` are all zero. A byte access is never misaligned.
- R6: An aligned load sets `acc_rd`=1 and `acc_wr`=0. An aligned store sets `acc_wr`=1 and `acc_rd`=0.
- R7: On the response side, opcode 0x20 returns byte lane `rsp_lane` of `rsp_word` with sign fill, and 0x24 returns the same byte with zero fill.
- R8: Opcode 0x21 returns the halfword selected by `rsp_lane[1]` with sign fill, and 0x25 returns it with zero fill. Opcode 0x23 returns `rsp_word` unchanged.
- R9: `ld_valid` is high one edge after `rsp_valid` with a load opcode. It is low after `rsp_valid` low, or after a response carrying a store or unknown opcode.
- R10: While `rst` is high, every output is zero on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Load/store opcode |
| req_base | input | 32 | Base operand |
| req_disp | input | 16 | Signed displacement |
| req_src | input | 32 | Store source operand |
| acc_valid | output | 1 | Registered command valid |
| acc_addr | output | 32 | Byte address |
| acc_rd | output | 1 | Read strobe |
| acc_wr | output | 1 | Write strobe |
| acc_be | output | 4 | Lane enables |
| acc_wdata | output | 32 | Lane-replicated write data |
| acc_misalign | output | 1 | Misaligned access flag |
| rsp_valid | input | 1 | Read word present |
| rsp_op | input | 6 | Opcode of the returning load |
| rsp_lane | input | 2 | Low address bits of the returning load |
| rsp_word | input | 32 | Word read from memory |
| ld_valid | output | 1 | Extended load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The assertions assume that `rsp_lane` carries the low address bits of an aligned load, as issued earlier by the request side. The bench therefore presents halfword responses only with an even lane. The address property assumes every input is held stable from the sampling edge to the following edge. The bench meets this by changing inputs only on falling edges and by dropping `req_valid` between scenarios, so that the idle assertions also see real idle cycles.

// File: rtl/lsa_pkg.sv
`timescale 1ns/1ps
package lsa_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      legal;
    logic      is_load;
    logic      is_store;
    logic      unsgn;
    acc_size_e size;
  } acc_dec_t;

  // Map an opcode onto direction, width and fill rule
  function automatic acc_dec_t decode_op(input logic [5:0] op);
    acc_dec_t d;
    d = '{legal: 1'b0, is_load: 1'b0, is_store: 1'b0, unsgn: 1'b0, size: SZ_BYTE};
    case (op)
      6'h20: d = '{1'b1, 1'b1, 1'b0, 1'b0, SZ_BYTE};
      6'h21: d = '{1'b1, 1'b1, 1'b0, 1'b0, SZ_HALF};
      6'h23: d = '{1'b1, 1'b1, 1'b0, 1'b0, SZ_WORD};
      6'h24: d = '{1'b1, 1'b1, 1'b0, 1'b1, SZ_BYTE};
      6'h25: d = '{1'b1, 1'b1, 1'b0, 1'b1, SZ_HALF};
      6'h28: d = '{1'b1, 1'b0, 1'b1, 1'b0, SZ_BYTE};
      6'h29: d = '{1'b1, 1'b0, 1'b1, 1'b0, SZ_HALF};
      6'h2b: d = '{1'b1, 1'b0, 1'b1, 1'b0, SZ_WORD};
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lsa_addr_gen.sv
`timescale 1ns/1ps
module lsa_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  disp,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] disp_sx;

  assign disp_sx = {{EXT_W{disp[IMM_W-1]}}, disp};
  assign ea      = base + disp_sx;
endmodule

// File: rtl/lsa_store_steer.sv
`timescale 1ns/1ps
module lsa_store_steer
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int LB     = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [LB-1:0]     lane,
  input  logic              misal,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] byte_rep;
  logic [DATA_W-1:0] half_rep;
  logic [LB-1:0]     half_base;

  // Copy the low byte / halfword into every lane
  for (genvar g = 0; g < LANES; g++) begin : g_rep
    assign byte_rep[g*8 +: 8] = src[7:0];
    assign half_rep[g*8 +: 8] = src[(g % 2)*8 +: 8];
  end

  assign half_base = {lane[LB-1:1], 1'b0};

  always_comb begin
    be = '0;
    unique case (size)
      SZ_BYTE: be[lane] = 1'b1;
      SZ_HALF: be[half_base +: 2] = 2'b11;
      default: be = '1;
    endcase
    if (misal) be = '0;
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: wdata = byte_rep;
      SZ_HALF: wdata = half_rep;
      default: wdata = src;
    endcase
  end
endmodule

// File: rtl/lsa_load_extract.sv
`timescale 1ns/1ps
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int LB     = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic              unsgn,
  input  logic [LB-1:0]     lane,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result
);
  logic [7:0]    byte_sel;
  logic [15:0]   half_sel;
  logic [LB+2:0] byte_off;
  logic [LB+2:0] half_off;
  logic          fill;

  assign byte_off = {lane, 3'b000};
  assign half_off = {lane[LB-1:1], 4'b0000};
  assign byte_sel = word[byte_off +: 8];
  assign half_sel = word[half_off +: 16];

  always_comb begin
    fill = 1'b0;
    unique case (size)
      SZ_BYTE: begin
        fill   = ~unsgn & byte_sel[7];
        result = {{(DATA_W-8){fill}}, byte_sel};
      end
      SZ_HALF: begin
        fill   = ~unsgn & half_sel[15];
        result = {{(DATA_W-16){fill}}, half_sel};
      end
      default: result = word;
    endcase
  end
endmodule

// File: rtl/ldst_lane_align.sv
`timescale 1ns/1ps
module ldst_lane_align
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LB    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [5:0]        req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [IMM_W-1:0]  req_disp,
  input  logic [DATA_W-1:0] req_src,
  output logic              acc_valid,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_rd,
  output logic              acc_wr,
  output logic [LANES-1:0]  acc_be,
  output logic [DATA_W-1:0] acc_wdata,
  output logic              acc_misalign,
  input  logic              rsp_valid,
  input  logic [5:0]        rsp_op,
  input  logic [LB-1:0]     rsp_lane,
  input  logic [DATA_W-1:0] rsp_word,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  acc_dec_t          req_dec;
  acc_dec_t          rsp_dec;
  logic [ADDR_W-1:0] ea;
  logic [LB-1:0]     lane;
  logic              misal;
  logic              accept;
  logic [LANES-1:0]  be_n;
  logic [DATA_W-1:0] wd_n;
  logic [DATA_W-1:0] ext_n;
  logic              take_rsp;

  assign req_dec = decode_op(req_op);
  assign rsp_dec = decode_op(rsp_op);

  lsa_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) addr_i (
    .base (req_base),
    .disp (req_disp),
    .ea   (ea)
  );

  assign lane   = ea[LB-1:0];
  assign misal  = ((req_dec.size == SZ_HALF) && ea[0]) ||
                  ((req_dec.size == SZ_WORD) && (lane != '0));
  assign accept = req_valid && req_dec.legal;

  lsa_store_steer #(.DATA_W(DATA_W)) steer_i (
    .size  (req_dec.size),
    .lane  (lane),
    .misal (misal),
    .src   (req_src),
    .be    (be_n),
    .wdata (wd_n)
  );

  lsa_load_extract #(.DATA_W(DATA_W)) extract_i (
    .size   (rsp_dec.size),
    .unsgn  (rsp_dec.unsgn),
    .lane   (rsp_lane),
    .word   (rsp_word),
    .result (ext_n)
  );

  assign take_rsp = rsp_valid && rsp_dec.legal && rsp_dec.is_load;

  // Request side: one register stage toward memory
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid    <= 1'b0;
      acc_addr     <= '0;
      acc_rd       <= 1'b0;
      acc_wr       <= 1'b0;
      acc_be       <= '0;
      acc_wdata    <= '0;
      acc_misalign <= 1'b0;
    end else begin
      acc_valid <= accept;
      if (accept) begin
        acc_addr     <= ea;
        acc_rd       <= req_dec.is_load  & ~misal;
        acc_wr       <= req_dec.is_store & ~misal;
        acc_be       <= be_n;
        acc_wdata    <= req_dec.is_store ? wd_n : '0;
        acc_misalign <= misal;
      end else begin
        acc_rd       <= 1'b0;
        acc_wr       <= 1'b0;
        acc_be       <= '0;
        acc_misalign <= 1'b0;
      end
    end
  end

  // Response side: one register stage toward the core
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= take_rsp;
      if (take_rsp) ld_data <= ext_n;
    end
  end
endmodule

// File: rtl/lsa_checker.sv
`timescale 1ns/1ps
module lsa_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int LANES  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_base,
  input logic [IMM_W-1:0]  req_disp,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic [LANES-1:0]  acc_be,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              acc_misalign,
  input logic              rsp_valid,
  input logic              ld_valid
);
  logic [ADDR_W-1:0] want_addr;
  assign want_addr = req_base + {{(ADDR_W-IMM_W){req_disp[IMM_W-1]}}, req_disp};

  a_r1_idle_no_cmd: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!acc_valid && !acc_rd && !acc_wr && acc_be == '0));

  a_r2_ea_sum: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!acc_valid || acc_addr == $past(want_addr)));

  a_r3_be_shape: assert property (@(posedge clk) disable iff (rst)
    (acc_rd || acc_wr) |-> ($countones(acc_be) == 1 || $countones(acc_be) == 2 ||
                            $countones(acc_be) == LANES));

  a_r4_byte_replicated: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && $countones(acc_be) == 1) |-> (acc_wdata == {LANES{acc_wdata[7:0]}}));

  a_r5_misalign_quiet: assert property (@(posedge clk) disable iff (rst)
    acc_misalign |-> (acc_be == '0 && !acc_rd && !acc_wr && acc_valid));

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(acc_rd && acc_wr));

  a_r9_no_ld_when_idle: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |=> !ld_valid);

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!acc_valid && !ld_valid && !acc_misalign));
endmodule

bind ldst_lane_align lsa_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_W(IMM_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_base     (req_base),
  .req_disp     (req_disp),
  .acc_valid    (acc_valid),
  .acc_addr     (acc_addr),
  .acc_rd       (acc_rd),
  .acc_wr       (acc_wr),
  .acc_be       (acc_be),
  .acc_wdata    (acc_wdata),
  .acc_misalign (acc_misalign),
  .rsp_valid    (rsp_valid),
  .ld_valid     (ld_valid)
);

// File: tb/ldst_lane_align_tb_top.sv
`timescale 1ns/1ps
module ldst_lane_align_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [5:0]  req_op = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic [31:0] req_src = '0;
  logic        acc_valid, acc_rd, acc_wr, acc_misalign;
  logic [31:0] acc_addr, acc_wdata;
  logic [3:0]  acc_be;
  logic        rsp_valid = 1'b0;
  logic [5:0]  rsp_op = '0;
  logic [1:0]  rsp_lane = '0;
  logic [31:0] rsp_word = '0;
  logic        ld_valid;
  logic [31:0] ld_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  ldst_lane_align dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_base(req_base),
    .req_disp(req_disp), .req_src(req_src),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_rd(acc_rd),
    .acc_wr(acc_wr), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .acc_misalign(acc_misalign),
    .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_lane(rsp_lane),
    .rsp_word(rsp_word), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bench-side model of the request stage
  function automatic int op_bytes(input logic [5:0] op);
    case (op)
      6'h20, 6'h24, 6'h28: return 1;
      6'h21, 6'h25, 6'h29: return 2;
      default:             return 4;
    endcase
  endfunction

  task automatic run_req(input string tag, input logic [5:0] op, input logic [31:0] base,
                         input logic [15:0] disp, input logic [31:0] src);
    logic [31:0] ea;
    logic        st, bad;
    logic [3:0]  be;
    logic [31:0] wd;
    int          nb;
    ea = base + 32'($signed(disp));
    st = (op[3] == 1'b1);
    nb = op_bytes(op);
    bad = (nb == 2 && ea[0]) || (nb == 4 && ea[1:0] != 2'b00);
    if (bad)          be = 4'b0000;
    else if (nb == 1) be = 4'b0001 << ea[1:0];
    else if (nb == 2) be = ea[1] ? 4'b1100 : 4'b0011;
    else              be = 4'b1111;
    if (!st)          wd = 32'h0;
    else if (nb == 1) wd = {src[7:0], src[7:0], src[7:0], src[7:0]};
    else if (nb == 2) wd = {src[15:0], src[15:0]};
    else              wd = src;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_base = base; req_disp = disp; req_src = src;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check({tag, " R1 valid"}, 32'(acc_valid), 32'd1);
    check({tag, " R2 addr"}, acc_addr, ea);
    check({tag, " R3 be"}, 32'(acc_be), 32'(be));
    check({tag, " R4 wdata"}, acc_wdata, wd);
    check({tag, " R5 misalign"}, 32'(acc_misalign), 32'(bad));
    check({tag, " R6 rd"}, 32'(acc_rd), 32'(!st && !bad));
    check({tag, " R6 wr"}, 32'(acc_wr), 32'(st && !bad));
  endtask

  task automatic run_drop(input string tag, input logic [5:0] op, input logic rv);
    @(negedge clk);
    req_valid = rv; req_op = op; req_base = 32'h100; req_disp = 16'h0; req_src = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check({tag, " R1 no valid"}, 32'(acc_valid), 32'd0);
    check({tag, " R1 no strobes"}, {26'd0, acc_rd, acc_wr, acc_be}, 32'd0);
  endtask

  task automatic run_rsp(input string tag, input logic [5:0] op, input logic [1:0] lane,
                         input logic [31:0] word, input logic exp_v, input logic [31:0] exp_d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_op = op; rsp_lane = lane; rsp_word = word;
    @(posedge clk); #1;
    rsp_valid = 1'b0;
    check({tag, " R9 ld_valid"}, 32'(ld_valid), 32'(exp_v));
    if (exp_v) check({tag, " data"}, ld_data, exp_d);
  endtask

  task automatic run_reset;
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R10 reset acc", {25'd0, acc_valid, acc_rd, acc_wr, acc_misalign, acc_be[2:0]}, 32'd0);
    check("R10 reset be", 32'(acc_be), 32'd0);
    check("R10 reset ld", 32'(ld_valid), 32'd0);
    check("R10 reset data", acc_wdata | acc_addr | ld_data, 32'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    run_reset();
    // stores
    run_req("sb lane3 neg disp", 6'h28, 32'h0000_1000, 16'hFFFF, 32'h1234_56C3);
    run_req("sb lane1",          6'h28, 32'h0000_2001, 16'h0000, 32'h0000_0077);
    run_req("sh upper",          6'h29, 32'h0000_2000, 16'h0002, 32'hDEAD_BEEF);
    run_req("sh lower",          6'h29, 32'h0000_3000, 16'h0000, 32'h0000_A55A);
    run_req("sw absolute",       6'h2b, 32'h0000_0000, 16'h0040, 32'hCAFE_F00D);
    run_req("sw misaligned",     6'h2b, 32'h0000_0000, 16'h0002, 32'h1111_2222);
    run_req("sh misaligned",     6'h29, 32'h0000_0005, 16'h0000, 32'h3333_4444);
    // loads
    run_req("lw indirect",       6'h23, 32'h8765_4320, 16'h0000, 32'h0);
    run_req("lw wrap",           6'h23, 32'hFFFF_FFFE, 16'h0006, 32'h0);
    run_req("lhu misaligned",    6'h25, 32'h0000_0010, 16'h0003, 32'h0);
    run_req("lbu lane3",         6'h24, 32'h0000_0010, 16'h0003, 32'h0);
    run_req("lh neg disp",       6'h21, 32'h0001_0000, 16'h8000, 32'h0);
    // illegal / idle
    run_drop("opcode 0x22", 6'h22, 1'b1);
    run_drop("opcode 0x2a", 6'h2a, 1'b1);
    run_drop("idle", 6'h23, 1'b0);
    // responses
    run_rsp("R7 lb lane2",  6'h20, 2'd2, 32'h12AB_3456, 1'b1, 32'hFFFF_FFAB);
    run_rsp("R7 lbu lane2", 6'h24, 2'd2, 32'h12AB_3456, 1'b1, 32'h0000_00AB);
    run_rsp("R7 lb lane0",  6'h20, 2'd0, 32'h12AB_3456, 1'b1, 32'h0000_0056);
    run_rsp("R8 lh upper",  6'h21, 2'd2, 32'h8001_7FFF, 1'b1, 32'hFFFF_8001);
    run_rsp("R8 lhu upper", 6'h25, 2'd2, 32'h8001_7FFF, 1'b1, 32'h0000_8001);
    run_rsp("R8 lh lower",  6'h21, 2'd0, 32'h8001_7FFF, 1'b1, 32'h0000_7FFF);
    run_rsp("R8 lw",        6'h23, 2'd0, 32'h9ABC_DEF0, 1'b1, 32'h9ABC_DEF0);
    run_rsp("R9 store op",  6'h28, 2'd0, 32'h5555_5555, 1'b0, 32'h0);
    run_rsp("R9 bad op",    6'h26, 2'd0, 32'h5555_5555, 1'b0, 32'h0);
    @(negedge clk);
    @(posedge clk); #1;
    check("R9 no rsp", 32'(ld_valid), 32'd0);
    run_reset();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule